// File: doc/BRIEF.md
# Keyboard Latch and I/O Read Decoder

This block keeps the most recent key code for an 8-bit processor system and places it in the processor's I/O space. The host side presents a raw character on `key_char` with a one-cycle `key_valid` pulse. The block applies a fixed character translation and folds lowercase letters to uppercase. It then sets a "key waiting" flag in bit 7 and stores the byte in a latch.

The processor polls the latch at the key address, 0xC000. Any access to the strobe address, 0xC010, clears the waiting flag and leaves the seven character bits readable. The access can be a read or a write, and a write's data is ignored. A read decoder steers `rd_data` from external RAM below 0xC000, from external ROM at 0xD000 and above, or from the latch. It returns zero for every other I/O address. It also reports which source it picked on a one-hot0 select.

Top module: `kbd_io_top`

## Requirements
- R1: After a synchronous active-low reset, the latch holds 0x00, so a read of 0xC000 returns 0x00.
- R2: `rd_data` at address 0xC000 is the full latched byte, bit 7 included. Reading there does not change the latch.
- R3: `rd_data` at address 0xC010 is the latched byte with bit 7 forced to 0. A read access (`bus_rd`=1) there clears bit 7 of the latch at the next clock edge and keeps bits 6..0.
- R4: A write access (`bus_wr`=1) to 0xC010 with any write data clears bit 7 of the latch at the next clock edge and keeps bits 6..0.
- R5: A new key code is translated before it is stored: 0x0A becomes 0x0D, 0x04 and 0x07 become 0x08, and 0x05 becomes 0x15.
- R6: After the R5 mapping, a code strictly greater than 0x60 and strictly less than 0x7B has bit 5 cleared. The codes 0x60 and 0x7B are left unchanged.
- R7: Bit 7 of every stored key is 1, whatever bit 7 of the raw code was. All other codes keep their bits 6..0. The latched value appears one clock edge after the `key_valid` cycle.
- R8: If `key_valid` and a strobe access fall in the same cycle, the new key is stored with bit 7 set.
- R9: When neither a key nor a strobe access occurs, the latch keeps its value.
- R10: An address below 0xC000 asserts `ram_sel` and returns `ram_rdata`. An address of 0xD000 or above asserts `rom_sel` and returns `rom_rdata`.
- R11: Addresses 0xC000 and 0xC010 assert `kbd_sel`. Every other address from 0xC000 to 0xCFFF asserts no select and returns 0x00. At most one select is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_valid | input | 1 | One-cycle pulse: a new raw key code is present |
| key_char | input | 8 | Raw key code from the host |
| bus_addr | input | 16 | Processor address |
| bus_rd | input | 1 | Read access this cycle |
| bus_wr | input | 1 | Write access this cycle |
| ram_rdata | input | 8 | Data returned by external RAM |
| rom_rdata | input | 8 | Data returned by external ROM |
| ram_sel | output | 1 | Address decodes to RAM |
| rom_sel | output | 1 | Address decodes to ROM |
| kbd_sel | output | 1 | Address decodes to the key or strobe address |
| rd_data | output | 8 | Read data from the selected source |

## Verification
Some properties are checked on every cycle:
- a key sets the flag one edge later;
- a strobe without a key clears the flag and keeps the character bits;
- the latch stays stable when idle;
- the selects are one-hot0;
- an unselected address reads zero.

The translation table, the uppercase window edges at 0x60 and 0x7B, and the exact byte returned at each address can only be shown by the bench. Its random mix of keys, strobe reads and writes, and addresses is compared against a reference model written from the requirements.

// File: rtl/kbd_io_pkg.sv
// Package: address map and width constants shared by the keyboard I/O block.
// Assumes a 16-bit address bus and 8-bit data bus.
package kbd_io_pkg;
    localparam int ADDR_W      = 16;
    localparam int DATA_W      = 8;
    localparam logic [ADDR_W-1:0] IO_BASE     = 16'hC000;
    localparam logic [ADDR_W-1:0] ROM_BASE    = 16'hD000;
    localparam logic [ADDR_W-1:0] KEY_ADDR    = 16'hC000;
    localparam logic [ADDR_W-1:0] STROBE_ADDR = 16'hC010;
    localparam int FLAG_BIT    = DATA_W - 1;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_RAM  = 2'd1,
        SRC_ROM  = 2'd2,
        SRC_KBD  = 2'd3
    } rd_src_e;
endpackage

// File: rtl/key_xlate.sv
// Module: key_xlate
// Converts a raw host key code into the stored form: control-code
// remapping, lowercase folding, then forces the ready flag in the top bit.
// Assumes 8-bit codes; purely combinational.
module key_xlate
    import kbd_io_pkg::*;
(
    input  logic [DATA_W-1:0] raw_code,
    output logic [DATA_W-1:0] stored_code
);
    logic [DATA_W-1:0] mapped;
    logic [DATA_W-1:0] folded;

    // Remap the few control codes the system expects differently.
    always_comb begin
        case (raw_code)
            8'h0A:        mapped = 8'h0D;
            8'h04, 8'h07: mapped = 8'h08;
            8'h05:        mapped = 8'h15;
            default:      mapped = raw_code;
        endcase
    end

    // Fold lowercase to uppercase, then set the ready flag.
    always_comb begin
        folded = mapped;
        if ((mapped > 8'h60) && (mapped < 8'h7B)) begin
            folded[5] = 1'b0;
        end
        stored_code           = folded;
        stored_code[FLAG_BIT] = 1'b1;
    end
endmodule

// File: rtl/key_latch.sv
// Module: key_latch
// Holds the last translated key. A new key has priority over a strobe
// access, which clears only the ready flag. Synchronous active-low reset.
module key_latch
    import kbd_io_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_code,
    input  logic              strobe,
    output logic [DATA_W-1:0] latch_q
);
    // Update the latch: reset, new key, strobe clear, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (load) begin
            latch_q <= load_code;
        end else if (strobe) begin
            latch_q[FLAG_BIT] <= 1'b0;
        end
    end

    // R1: reset leaves the latch empty.
    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> (latch_q == '0));

    // R7: a key always arrives with the flag set (R8: even with a strobe).
    assert_key_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> latch_q[FLAG_BIT]);

    // R3 / R4: a strobe without a key clears the flag and keeps the character.
    assert_strobe_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !load) |=> (!latch_q[FLAG_BIT] &&
                               latch_q[FLAG_BIT-1:0] == $past(latch_q[FLAG_BIT-1:0])));

    // R9: idle cycles do not disturb the latch.
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !load) |=> $stable(latch_q));
endmodule

// File: rtl/bus_rdmux.sv
// Module: bus_rdmux
// Decodes the processor address into RAM / ROM / keyboard selects and
// muxes the read data. The strobe address reads the latch without its flag.
// Assumes selects depend on address only; clk/rst_n feed assertions.
module bus_rdmux
    import kbd_io_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic [DATA_W-1:0] rom_rdata,
    input  logic [DATA_W-1:0] latch_q,
    output logic              ram_sel,
    output logic              rom_sel,
    output logic              kbd_sel,
    output logic              strobe_hit,
    output logic [DATA_W-1:0] rd_data
);
    rd_src_e src;

    // Choose the source for the current address.
    always_comb begin
        if (addr < IO_BASE)                                src = SRC_RAM;
        else if (addr >= ROM_BASE)                         src = SRC_ROM;
        else if (addr == KEY_ADDR || addr == STROBE_ADDR) src = SRC_KBD;
        else                                               src = SRC_NONE;
    end

    // Drive selects and the read-data mux from the chosen source.
    always_comb begin
        ram_sel    = (src == SRC_RAM);
        rom_sel    = (src == SRC_ROM);
        kbd_sel    = (src == SRC_KBD);
        strobe_hit = (addr == STROBE_ADDR);
        case (src)
            SRC_RAM: rd_data = ram_rdata;
            SRC_ROM: rd_data = rom_rdata;
            SRC_KBD: begin
                rd_data = latch_q;
                if (strobe_hit) rd_data[FLAG_BIT] = 1'b0;
            end
            default: rd_data = '0;
        endcase
    end

    // R11: never more than one source selected.
    assert_sel_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_sel, rom_sel, kbd_sel}));

    // R11: an unselected address reads zero.
    assert_unsel_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_sel || rom_sel || kbd_sel) |-> (rd_data == '0));

    // R3: the strobe address never shows the ready flag.
    assert_strobe_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_hit |-> !rd_data[FLAG_BIT]);
endmodule

// File: rtl/kbd_io_top.sv
// Module: kbd_io_top
// Keyboard latch with strobe clear plus the I/O read decoder.
// Assumes single-cycle bus accesses; a strobe is any read or write at the
// strobe address. Synchronous active-low reset.
module kbd_io_top (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_valid,
    input  logic [7:0]  key_char,
    input  logic [15:0] bus_addr,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [7:0]  ram_rdata,
    input  logic [7:0]  rom_rdata,
    output logic        ram_sel,
    output logic        rom_sel,
    output logic        kbd_sel,
    output logic [7:0]  rd_data
);
    import kbd_io_pkg::*;

    logic [DATA_W-1:0] xlated;
    logic [DATA_W-1:0] latch_q;
    logic              strobe_hit;
    logic              strobe;

    // A strobe is any access, read or write, to the strobe address.
    always_comb strobe = strobe_hit && (bus_rd || bus_wr);

    key_xlate u_xlate (
        .raw_code    (key_char),
        .stored_code (xlated)
    );

    key_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (key_valid),
        .load_code (xlated),
        .strobe    (strobe),
        .latch_q   (latch_q)
    );

    bus_rdmux u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (bus_addr),
        .ram_rdata  (ram_rdata),
        .rom_rdata  (rom_rdata),
        .latch_q    (latch_q),
        .ram_sel    (ram_sel),
        .rom_sel    (rom_sel),
        .kbd_sel    (kbd_sel),
        .strobe_hit (strobe_hit),
        .rd_data    (rd_data)
    );
endmodule

// File: tb/kbd_io_top_bench.sv
`timescale 1ns/1ps
module kbd_io_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key_valid = 1'b0;
    logic [7:0]  key_char = '0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  ram_rdata = '0;
    logic [7:0]  rom_rdata = '0;
    logic        ram_sel, rom_sel, kbd_sel;
    logic [7:0]  rd_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [7:0] model = '0;

    always #2.5 clk = ~clk;

    kbd_io_top u_kbd_io_top (
        .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_char(key_char),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .ram_rdata(ram_rdata), .rom_rdata(rom_rdata),
        .ram_sel(ram_sel), .rom_sel(rom_sel), .kbd_sel(kbd_sel), .rd_data(rd_data)
    );

    // Stored form of a raw key per R5, R6, R7.
    function automatic logic [7:0] exp_key(input logic [7:0] c);
        logic [7:0] t;
        if (c == 8'h0A) t = 8'h0D;
        else if (c == 8'h04 || c == 8'h07) t = 8'h08;
        else if (c == 8'h05) t = 8'h15;
        else t = c;
        if (t > 8'h60 && t < 8'h7B) t = t & 8'hDF;
        return t | 8'h80;
    endfunction

    // Expected read data and select vector per R2, R3, R10, R11.
    function automatic logic [7:0] exp_rd(input logic [15:0] a, input logic [7:0] lat,
                                          input logic [7:0] ram, input logic [7:0] rom);
        if (a < 16'hC000) return ram;
        if (a >= 16'hD000) return rom;
        if (a == 16'hC000) return lat;
        if (a == 16'hC010) return lat & 8'h7F;
        return 8'h00;
    endfunction

    function automatic logic [2:0] exp_sel(input logic [15:0] a);
        if (a < 16'hC000) return 3'b100;
        if (a >= 16'hD000) return 3'b010;
        if (a == 16'hC000 || a == 16'hC010) return 3'b001;
        return 3'b000;
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, check combinational outputs, advance model at posedge.
    task automatic step(input string req, input logic kv, input logic [7:0] ch,
                        input logic [15:0] a, input logic rd, input logic wr);
        @(negedge clk);
        key_valid = kv; key_char = ch; bus_addr = a; bus_rd = rd; bus_wr = wr;
        ram_rdata = 8'($urandom); rom_rdata = 8'($urandom);
        #1;
        check8(req, rd_data, exp_rd(a, model, ram_rdata, rom_rdata));
        check8({req, " sel"}, {5'b0, ram_sel, rom_sel, kbd_sel}, {5'b0, exp_sel(a)});
        @(posedge clk);
        if (kv) model = exp_key(ch);
        else if (a == 16'hC010 && (rd || wr)) model = model & 8'h7F;
        #0.1;
        key_valid = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic key_then_peek(input string req, input logic [7:0] ch, input logic [7:0] exp);
        step(req, 1'b1, ch, 16'h0000, 1'b0, 1'b0);
        step(req, 1'b0, 8'h00, 16'hC000, 1'b1, 1'b0);
        check8(req, model, exp);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset value
        step("R1", 1'b0, 8'h00, 16'hC000, 1'b1, 1'b0);
        // R5 translation table
        key_then_peek("R5", 8'h0A, 8'h8D);
        key_then_peek("R5", 8'h04, 8'h88);
        key_then_peek("R5", 8'h07, 8'h88);
        key_then_peek("R5", 8'h05, 8'h95);
        // R6 window edges
        key_then_peek("R6", 8'h61, 8'hC1);
        key_then_peek("R6", 8'h7A, 8'hDA);
        key_then_peek("R6", 8'h60, 8'hE0);
        key_then_peek("R6", 8'h7B, 8'hFB);
        // R7 raw bit 7 already set, and plain pass-through
        key_then_peek("R7", 8'hC1, 8'hC1);
        key_then_peek("R7", 8'h33, 8'hB3);
        // R2: repeated key-address reads do not clear
        step("R2", 1'b0, 8'h00, 16'hC000, 1'b1, 1'b0);
        step("R2", 1'b0, 8'h00, 16'hC000, 1'b1, 1'b0);
        // R3: strobe read returns flagless byte, then flag clear
        step("R3", 1'b0, 8'h00, 16'hC010, 1'b1, 1'b0);
        step("R3", 1'b0, 8'h00, 16'hC000, 1'b1, 1'b0);
        check8("R3", rd_data, 8'h33);
        // R4: write to strobe clears
        key_then_peek("R4", 8'h41, 8'hC1);
        step("R4", 1'b0, 8'hFF, 16'hC010, 1'b0, 1'b1);
        step("R4", 1'b0, 8'h00, 16'hC000, 1'b1, 1'b0);
        check8("R4", rd_data, 8'h41);
        // R8: key and strobe together
        step("R8", 1'b1, 8'h62, 16'hC010, 1'b1, 1'b0);
        step("R8", 1'b0, 8'h00, 16'hC000, 1'b1, 1'b0);
        check8("R8", rd_data, 8'hC2);
        // R9: strobe address with no access does not clear
        step("R9", 1'b0, 8'h00, 16'hC010, 1'b0, 1'b0);
        step("R9", 1'b0, 8'h00, 16'hC000, 1'b0, 1'b0);
        check8("R9", rd_data, 8'hC2);
        // R10 / R11 address boundaries
        step("R10", 1'b0, 8'h00, 16'hBFFF, 1'b1, 1'b0);
        step("R10", 1'b0, 8'h00, 16'hD000, 1'b1, 1'b0);
        step("R10", 1'b0, 8'h00, 16'hFFFF, 1'b1, 1'b0);
        step("R11", 1'b0, 8'h00, 16'hC001, 1'b1, 1'b0);
        step("R11", 1'b0, 8'h00, 16'hC011, 1'b1, 1'b0);
        step("R11", 1'b0, 8'h00, 16'hCFFF, 1'b1, 1'b0);
        // Random mix (R2 R3 R4 R7 R9 R10 R11)
        for (int i = 0; i < 2000; i++) begin
            logic [15:0] a;
            int pick = $urandom_range(0, 5);
            case (pick)
                0: a = 16'hC000;
                1: a = 16'hC010;
                2: a = 16'hC000 + 16'($urandom_range(0, 16'h0FFF));
                default: a = 16'($urandom);
            endcase
            step("R7-mix", ($urandom_range(0, 3) == 0), 8'($urandom), a,
                 1'($urandom), 1'($urandom));
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule